// File: doc/BRIEF.md
# SPI Master/Slave Port with Mode Fault

This block moves 8-bit frames over a four-wire serial link. One 8-bit control register selects the role. As master the block drives the serial clock, sends on MOSI and samples MISO. As slave it takes the serial clock from its pin, samples MOSI and drives MISO while its select input is low. Writing the data port loads the next outgoing byte, and in master mode that write also starts the frame. Each frame ends with a received byte on `data_o` and a transfer-complete flag.

In master mode the clock is the system clock divided by one of six rates, chosen by a three-bit code whose bits are not in numeric order. If the select input goes low while the block is master, another master is driving the bus. The block then drops out of master mode, releases every pin driver and raises a mode-fault flag. Either flag can raise an interrupt request. Software clears each flag with a write-one strobe.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, both flags and `irq_o` are low, all three output enables are low and `sck_o` is low.
- R2: The control register reads back as written, with this layout: bit 7 interrupt enable, bit 6 pin enable, bit 5 divider select, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate.
- R3: In master mode the code {bit5, bit1, bit0} sets the SCK period in system clocks: 100 and 101 give 4, 000 gives 8, 001 gives 16, 110 gives 32, 010 gives 64, and 011 and 111 give 128. Each SCK half period lasts half that many clocks.
- R4: Frames are shifted most significant bit first. In master mode the byte written to the data port appears on `mosi_o`, and the byte sampled from `miso_i` is presented on `data_o` when the frame ends.
- R5: SCK rests at the level of clock polarity whenever no master frame is running, in both master and slave modes. In master mode with pin enable set, `sck_oe_o` and `mosi_oe_o` are high.
- R6: With clock phase 0, data is sampled on SCK transitions 1, 3, ... 15 of a frame. With clock phase 1, it is sampled on transitions 2, 4, ... 16. The done flag rises at the eighth sample, which is 15 (phase 0) or 16 (phase 1) half periods after the clock edge that takes in the data write.
- R7: In slave mode SCK is taken from `sck_i`, data is sampled from `mosi_i`, and the byte written beforehand is sent on `miso_o`. `miso_oe_o` is high only while `ss_ni` is low. The rate bits have no effect in this mode.
- R8: If `ss_ni` is seen low while the master bit is 1, the pin-enable and master bits clear, any running frame stops, and `fault_o` sets.
- R9: `irq_o` is high while interrupt enable is 1 and either flag is set, and low while interrupt enable is 0.
- R10: A strobe on `flag_clr_i[0]` clears the done flag and a strobe on `flag_clr_i[1]` clears the fault flag.
- R11: With pin enable 0, all output enables are low, SCK edges on `sck_i` are ignored (no done flag, `data_o` unchanged), and a data write starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_o | output | 8 | Control register contents |
| data_wr_i | input | 1 | Data write strobe (loads outgoing byte, starts a master frame) |
| data_wdata_i | input | DATA_W | Outgoing byte |
| data_o | output | DATA_W | Last received byte |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 done, bit 1 fault |
| done_o | output | 1 | Transfer-complete flag |
| fault_o | output | 1 | Mode-fault flag |
| irq_o | output | 1 | Interrupt request |
| ss_ni | input | 1 | Slave select, active low |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe_o | output | 1 | MISO output enable |

## Verification
A wrong divider count or edge counter shows at once in the done timing: the flag rises some whole number of half periods away from 15 or 16. It also leaves SCK resting at the wrong level after the frame. A shift or phase fault shows when the frame ends, as a byte mismatch on `data_o` or in the bits the bench samples from the data output. A fault path that fails to clear the role bits shows within three clocks of select going low, in `ctrl_o` and the output enables.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int unsigned DIV_MAX    = 128;
  localparam int unsigned HALF_CNT_W = $clog2(DIV_MAX / 2);

  typedef struct packed {
    logic       irq_en;
    logic       pin_en;
    logic       div_off;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // log2 of the SCK half period in system clocks, from {div_off, rate}
  function automatic logic [2:0] half_log2(input logic [2:0] code);
    case (code)
      3'b100, 3'b101: half_log2 = 3'd1;
      3'b000:         half_log2 = 3'd2;
      3'b001:         half_log2 = 3'd3;
      3'b110:         half_log2 = 3'd4;
      3'b010:         half_log2 = 3'd5;
      default:        half_log2 = 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       fault_set_i,
  input  logic       done_set_i,
  input  logic [1:0] clr_i,
  output ctrl_t      ctrl_o,
  output logic       done_o,
  output logic       fault_o
);

  ctrl_t ctrl_q;
  logic  done_q, fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (wr_i) ctrl_q <= ctrl_t'(wdata_i);
      // hardware override wins over a same-cycle write
      if (fault_set_i) begin
        ctrl_q.pin_en <= 1'b0;
        ctrl_q.master <= 1'b0;
      end
      if (done_set_i)    done_q <= 1'b1;
      else if (clr_i[0]) done_q <= 1'b0;
      if (fault_set_i)   fault_q <= 1'b1;
      else if (clr_i[1]) fault_q <= 1'b0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign done_o  = done_q;
  assign fault_o = fault_q;

endmodule

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv
  import spi_port_pkg::*;
#(
  parameter int unsigned CNT_W = HALF_CNT_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] code_i,
  output logic       tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim    = CNT_W'((32'd1 << half_log2(code_i)) - 32'd1);
    tick_o = run_i && (cnt_q == lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mst_i,
  input  logic              slv_i,
  input  logic              cpha_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              sck_edge_i,
  input  logic              sel_i,
  input  logic              miso_i,
  input  logic              mosi_i,
  output logic              busy_o,
  output logic              lvl_o,
  output logic              ser_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              done_o
);

  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned EC_W  = $clog2(EDGES);

  logic [EC_W-1:0]   ecnt_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [DATA_W-2:0] rx_sh_q;
  logic              busy_q, lvl_q;
  logic              edge_s, in_bit, cap, launch, last_edge, active;

  always_comb begin
    active    = (mst_i && busy_q) || (slv_i && sel_i);
    edge_s    = mst_i ? (busy_q && tick_i) : (slv_i && sel_i && sck_edge_i);
    in_bit    = mst_i ? miso_i : mosi_i;
    cap       = edge_s && (ecnt_q[0] == cpha_i);
    // first transition of a frame never shifts: bit MSB is already presented
    launch    = edge_s && (ecnt_q[0] != cpha_i) && (ecnt_q != '0);
    last_edge = ecnt_q == EC_W'(EDGES - 1);
    done_o    = cap && (ecnt_q[EC_W-1:1] == (EC_W-1)'(DATA_W - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecnt_q  <= '0;
      lvl_q   <= 1'b0;
      busy_q  <= 1'b0;
      tx_q    <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
    end else begin
      if (!active) begin
        ecnt_q <= '0;
        lvl_q  <= 1'b0;
      end else if (edge_s) begin
        ecnt_q <= last_edge ? '0 : ecnt_q + EC_W'(1);
        lvl_q  <= ~lvl_q;
      end

      if (load_i)      tx_q <= tx_i;
      else if (launch) tx_q <= {tx_q[DATA_W-2:0], 1'b0};

      if (!mst_i)                     busy_q <= 1'b0;
      else if (load_i)                busy_q <= 1'b1;
      else if (edge_s && last_edge)   busy_q <= 1'b0;

      if (cap)    rx_sh_q <= {rx_sh_q[DATA_W-3:0], in_bit};
      if (done_o) rx_q    <= {rx_sh_q, in_bit};
    end
  end

  assign busy_o = busy_q;
  assign lvl_o  = lvl_q;
  assign ser_o  = tx_q[DATA_W-1];
  assign rx_o   = rx_q;

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic [7:0]        ctrl_o,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  output logic [DATA_W-1:0] data_o,
  input  logic [1:0]        flag_clr_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              irq_o,
  input  logic              ss_ni,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o
);

  // {ss_n, sck, mosi} synchronizer chain
  logic [2:0] sync_q [SYNC_STAGES];
  logic       sck_prev_q;
  logic       ss_s, sck_s, mosi_s, sck_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b100;
      sck_prev_q <= 1'b0;
    end else begin
      sync_q[0] <= {ss_ni, sck_i, mosi_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      sck_prev_q <= sck_s;
    end
  end

  assign ss_s     = sync_q[SYNC_STAGES-1][2];
  assign sck_s    = sync_q[SYNC_STAGES-1][1];
  assign mosi_s   = sync_q[SYNC_STAGES-1][0];
  assign sck_edge = sck_s ^ sck_prev_q;

  ctrl_t ctrl;
  logic  mst, slv, busy, tick, lvl, ser, done_pulse, fault_set, load;

  assign mst       = ctrl.pin_en && ctrl.master;
  assign slv       = ctrl.pin_en && !ctrl.master;
  assign fault_set = ctrl.master && !ss_s;
  assign load      = data_wr_i && (mst ? !busy : (slv && ss_s));

  spi_port_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctrl_wr_i),
    .wdata_i     (ctrl_wdata_i),
    .fault_set_i (fault_set),
    .done_set_i  (done_pulse),
    .clr_i       (flag_clr_i),
    .ctrl_o      (ctrl),
    .done_o      (done_o),
    .fault_o     (fault_o)
  );

  spi_port_clkdiv u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (mst && busy),
    .code_i ({ctrl.div_off, ctrl.rate}),
    .tick_o (tick)
  );

  spi_port_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mst_i      (mst),
    .slv_i      (slv),
    .cpha_i     (ctrl.cpha),
    .load_i     (load),
    .tx_i       (data_wdata_i),
    .tick_i     (tick),
    .sck_edge_i (sck_edge),
    .sel_i      (!ss_s),
    .miso_i     (miso_i),
    .mosi_i     (mosi_s),
    .busy_o     (busy),
    .lvl_o      (lvl),
    .ser_o      (ser),
    .rx_o       (data_o),
    .done_o     (done_pulse)
  );

  assign ctrl_o    = ctrl;
  assign irq_o     = ctrl.irq_en && (done_o || fault_o);
  assign sck_o     = mst ? (ctrl.cpol ^ lvl) : ctrl.cpol;
  assign sck_oe_o  = mst;
  assign mosi_o    = ser;
  assign mosi_oe_o = mst;
  assign miso_o    = ser;
  assign miso_oe_o = slv && !ss_s;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ctrl_i,
  input logic       done_i,
  input logic       fault_i,
  input logic       irq_i,
  input logic       sck_lvl_i,
  input logic       sck_oe_i,
  input logic       mosi_oe_i,
  input logic       miso_oe_i,
  input logic       busy_i,
  input logic       data_wr_i
);

  // R8
  fault_drops_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_i) |-> (!ctrl_i[6] && !ctrl_i[4]));

  // R9
  irq_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> (ctrl_i[7] && (done_i || fault_i)));

  // R11
  pins_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[6] |-> (!sck_oe_i && !mosi_oe_i && !miso_oe_i));

  // R5
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[6] && ctrl_i[4] && !busy_i) |-> (sck_lvl_i == ctrl_i[3]));

  // R11
  no_start_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !ctrl_i[6]) |=> !busy_i);

endmodule

bind spi_port spi_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_i    (ctrl_o),
  .done_i    (done_o),
  .fault_i   (fault_o),
  .irq_i     (irq_o),
  .sck_lvl_i (sck_o),
  .sck_oe_i  (sck_oe_o),
  .mosi_oe_i (mosi_oe_o),
  .miso_oe_i (miso_oe_o),
  .busy_i    (busy),
  .data_wr_i (data_wr_i)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0, data_wr = 1'b0;
  logic [7:0] ctrl_wd = '0, data_wd = '0;
  logic [7:0] ctrl_rd, data_rd;
  logic [1:0] clr = '0;
  logic       done, fault, irq;
  logic       ss_n = 1'b1, sck_in = 1'b0, mosi_in = 1'b0, miso_in;
  logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;

  always #5 clk = ~clk;

  spi_port dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wd), .ctrl_o(ctrl_rd),
    .data_wr_i(data_wr), .data_wdata_i(data_wd), .data_o(data_rd),
    .flag_clr_i(clr), .done_o(done), .fault_o(fault), .irq_o(irq),
    .ss_ni(ss_n), .sck_i(sck_in), .sck_o(sck_out), .sck_oe_o(sck_oe),
    .mosi_i(mosi_in), .mosi_o(mosi_out), .mosi_oe_o(mosi_oe),
    .miso_i(miso_in), .miso_o(miso_out), .miso_oe_o(miso_oe)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench-side slave model for master-mode frames
  bit         mdl_en = 1'b0;
  int         mdl_cpha = 0;
  logic       prev_sck = 1'b0;
  int         eidx = 0, ccnt = 0;
  logic [2:0] sbit = '0;
  logic [7:0] sl_tx = '0, cap_b = '0;

  assign miso_in = mdl_en ? sl_tx[~sbit] : 1'b0;

  always @(negedge clk) begin
    if (mdl_en) begin
      if (sck_out !== prev_sck) begin
        if ((eidx % 2) == mdl_cpha) begin
          if (ccnt < 8) cap_b[7-ccnt] = mosi_out;
          ccnt++;
        end else if (eidx != 0) sbit = sbit + 3'd1;
        eidx++;
      end
      prev_sck = sck_out;
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wd = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic clear(input logic [1:0] m);
    @(negedge clk); clr = m;
    @(negedge clk); clr = 2'b00;
  endtask

  function automatic int period_of(input logic [2:0] c);
    case (c)
      3'b100, 3'b101: return 4;
      3'b000:         return 8;
      3'b001:         return 16;
      3'b110:         return 32;
      3'b010:         return 64;
      default:        return 128;
    endcase
  endfunction

  task automatic master_xfer(input logic [2:0] code, input logic cpol, input logic cpha,
                             input logic [7:0] tx, input logic [7:0] stx);
    int half, n;
    half = period_of(code) / 2;
    wr_ctrl({1'b0, 1'b1, code[2], 1'b1, cpol, cpha, code[1:0]});
    clear(2'b11);
    chk(sck_out == cpol, "R5 idle level before frame", sck_out, cpol);
    chk(sck_oe && mosi_oe, "R5 master drivers on", {sck_oe, mosi_oe}, 3);
    sl_tx = stx; prev_sck = cpol; eidx = 0; ccnt = 0; sbit = '0; cap_b = '0;
    mdl_cpha = int'(cpha); mdl_en = 1'b1;
    @(negedge clk); data_wr = 1'b1; data_wd = tx;
    @(posedge clk); #1; data_wr = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk); #1; n++;
    end
    chk(n == (15 + int'(cpha)) * half, "R3 R6 done timing", n, (15 + int'(cpha)) * half);
    repeat (half + 2) @(negedge clk);
    mdl_en = 1'b0;
    chk(data_rd == stx, "R4 received byte", data_rd, stx);
    chk(cap_b == tx, "R4 MSB-first on mosi", cap_b, tx);
    chk(eidx == 16, "R6 sck transitions per frame", eidx, 16);
    chk(sck_out == cpol, "R5 idle level after frame", sck_out, cpol);
  endtask

  localparam int HP = 8;

  task automatic slave_xfer(input logic cpol, input logic cpha, input logic [2:0] code,
                            input logic [7:0] stx, input logic [7:0] mtx);
    logic [7:0] mrx;
    mrx = '0;
    sck_in = cpol;
    wr_ctrl({1'b0, 1'b1, code[2], 1'b0, cpol, cpha, code[1:0]});
    clear(2'b11);
    repeat (6) @(negedge clk);
    chk(sck_out == cpol, "R5 slave sck level", sck_out, cpol);
    @(negedge clk); data_wr = 1'b1; data_wd = stx;
    @(negedge clk); data_wr = 1'b0;
    ss_n = 1'b0;
    mosi_in = cpha ? 1'b0 : mtx[7];
    repeat (HP) @(negedge clk);
    chk(miso_oe == 1'b1, "R7 miso driven while selected", miso_oe, 1);
    for (int i = 0; i < 8; i++) begin
      sck_in = ~sck_in;
      if (!cpha) mrx[7-i] = miso_out;
      else       mosi_in = mtx[7-i];
      repeat (HP) @(negedge clk);
      sck_in = ~sck_in;
      if (!cpha) begin
        if (i < 7) mosi_in = mtx[6-i];
      end else mrx[7-i] = miso_out;
      repeat (HP) @(negedge clk);
    end
    chk(done == 1'b1, "R7 slave done", done, 1);
    chk(data_rd == mtx, "R7 slave received byte", data_rd, mtx);
    chk(mrx == stx, "R7 slave sent byte", mrx, stx);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(miso_oe == 1'b0, "R7 miso released", miso_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(ctrl_rd == 8'h00, "R1 ctrl reset", ctrl_rd, 0);
    chk(!done && !fault && !irq, "R1 flags reset", {done, fault, irq}, 0);
    chk(!sck_oe && !mosi_oe && !miso_oe && !sck_out, "R1 pins reset",
        {sck_oe, mosi_oe, miso_oe, sck_out}, 0);

    // R2
    wr_ctrl(8'h2E); @(negedge clk);
    chk(ctrl_rd == 8'h2E, "R2 readback", ctrl_rd, 8'h2E);
    wr_ctrl(8'hFF); @(negedge clk);
    chk(ctrl_rd == 8'hFF, "R2 readback all ones", ctrl_rd, 8'hFF);
    wr_ctrl(8'h00);

    // R3 R4 R5 R6: every rate code in both phases
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 2; p++) begin
        master_xfer(3'(c), 1'((c ^ p) & 1), 1'(p), 8'(8'hA5 ^ (c * 37 + p * 91)),
                    8'(8'h3C ^ (c * 19 + p * 113)));
      end
    end

    // R9 enable gates the request, R10 done clear
    chk(done && !irq, "R9 no irq when disabled", irq, 0);
    wr_ctrl(8'h80); @(negedge clk);
    chk(irq == 1'b1, "R9 irq on done", irq, 1);
    clear(2'b01);
    chk(!done && !irq, "R10 done cleared", {done, irq}, 0);

    // R8 mode fault mid-frame
    wr_ctrl(8'hD0);
    @(negedge clk); data_wr = 1'b1; data_wd = 8'h5A;
    @(negedge clk); data_wr = 1'b0;
    repeat (20) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(ctrl_rd == 8'h80, "R8 role bits cleared", ctrl_rd, 8'h80);
    chk(fault == 1'b1, "R8 fault flag", fault, 1);
    chk(!sck_oe && !mosi_oe, "R8 drivers released", {sck_oe, mosi_oe}, 0);
    chk(done == 1'b0, "R8 frame aborted", done, 0);
    chk(irq == 1'b1, "R9 irq on fault", irq, 1);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    clear(2'b10);
    chk(!fault && !irq, "R10 fault cleared", {fault, irq}, 0);

    // R7 slave in all four modes, rate bits varied
    slave_xfer(1'b0, 1'b0, 3'b011, 8'hC3, 8'h96);
    slave_xfer(1'b0, 1'b1, 3'b100, 8'h1E, 8'hE1);
    slave_xfer(1'b1, 1'b0, 3'b010, 8'h7B, 8'h48);
    slave_xfer(1'b1, 1'b1, 3'b111, 8'hA0, 8'h05);

    // R11 disabled slave ignores sck
    begin
      logic [7:0] old;
      wr_ctrl(8'h04);
      clear(2'b11);
      old = data_rd;
      ss_n = 1'b0;
      for (int i = 0; i < 16; i++) begin
        sck_in = ~sck_in; mosi_in = 1'(i % 3);
        repeat (HP) @(negedge clk);
      end
      chk(done == 1'b0, "R11 edges ignored", done, 0);
      chk(data_rd == old, "R11 data unchanged", data_rd, old);
      chk(!miso_oe, "R11 miso not driven", miso_oe, 0);
      ss_n = 1'b1;
    end

    // R11 disabled master does not start
    begin
      int toggles;
      logic last;
      wr_ctrl(8'h10);
      @(negedge clk); data_wr = 1'b1; data_wd = 8'hFF;
      @(negedge clk); data_wr = 1'b0;
      toggles = 0; last = sck_out;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (sck_out != last) toggles++;
        last = sck_out;
      end
      chk(toggles == 0 && !done, "R11 no frame when disabled", toggles, 0);
      chk(!sck_oe && !mosi_oe, "R11 drivers off", {sck_oe, mosi_oe}, 0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule